// File: doc/BRIEF.md
# ADC Sample Window Monitor

This block sits beside an analog-to-digital converter. It checks every converted sample against a small set of programmable windows, and it needs no processor to do so. Each cycle may carry one sample, marked by a valid strobe and tagged with a channel number and a 10-bit code, where 0x3FF is full scale. The block holds a parameterised number of limit slots, four by default. Each slot names one channel and has a low bound, a high bound, and separate enables for the check against each bound.

Every enabled slot whose channel matches the sample is evaluated in the strobe cycle. A sample above the high bound sets that slot's sticky high flag. A sample below the low bound sets its sticky low flag. An interrupt output and a wake-request output each reflect the OR of the pending flags, and each is gated by its own enable. A sleeping system can therefore be woken without raising the interrupt, and the reverse also works. Software reads and writes the slots, flags and enables through a simple word-wide register port with a single-cycle write strobe and combinational read data.

Top module: `adc_limit_monitor`

## Requirements
- R1: After synchronous reset, every register reads 0, no flag is pending, and both `irq_o` and `wake_o` are low.
- R2: Register addresses are {global, slot, word}. For slot s, address 2s holds the channel in bits [3:0], the low-check enable in bit 8 and the high-check enable in bit 9. Address 2s+1 holds the low bound in bits [9:0] and the high bound in bits [25:16]. Address 8 is the flag register and address 9 is the control register, with the interrupt enable in bit 0 and the wake enable in bit 1. Written fields read back unchanged. Unlisted bits and the unused addresses 10 to 15 read 0 and ignore writes.
- R3: A valid sample on a slot's channel whose code is strictly greater than the slot's high bound, with the high check enabled, sets that slot's high flag (bit 2s+1 of the flag register) on the next clock edge. A code equal to the bound sets nothing.
- R4: A valid sample on a slot's channel whose code is strictly less than the low bound, with the low check enabled, sets that slot's low flag (bit 2s). A code equal to the bound sets nothing.
- R5: No flag is set by a sample when the strobe is low, when the channel differs, or when the relevant check is disabled.
- R6: One sample is evaluated against every matching slot in the same cycle. Several slots may set flags from a single sample.
- R7: A flag stays set until a write to the flag register has a 1 in that flag's bit position. Writing 0 to a bit leaves that flag unchanged.
- R8: When a flag is cleared and set again in the same cycle, the set wins.
- R9: `irq_o` is high exactly when the interrupt enable is set and at least one flag is pending. It therefore rises in the cycle after the violating sample.
- R10: `wake_o` is high exactly when the wake enable is set and at least one flag is pending. It is independent of the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid_i | input | 1 | Sample strobe |
| smp_chan_i | input | 4 | Channel of the sample |
| smp_code_i | input | 10 | Converted code |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake request |

## Verification
Several kinds of internal fault are visible at the ports. A wrong comparison or a wrong channel match appears in the flag register and on `irq_o` or `wake_o` one clock after the offending sample. A flag that drops early or is never set shows up at the next read of the flag register. A corrupted slot field shows up on its readback, or later as a flag decision that disagrees with the bench's window model. The bench therefore reads the flags and both request lines after every cycle, so a fault is reported in the cycle where it first becomes visible.

// File: rtl/adc_lim_pkg.sv
package adc_lim_pkg;

    localparam int CODE_W = 10;
    localparam int CHAN_W = 4;
    localparam int DATA_W = 32;

    // Register field positions
    localparam int CFG_LO_EN_BIT = 8;
    localparam int CFG_HI_EN_BIT = 9;
    localparam int LIM_HI_LSB    = 16;
    localparam int CTRL_IRQ_BIT  = 0;
    localparam int CTRL_WAKE_BIT = 1;

    typedef struct packed {
        logic              hi_en;
        logic              lo_en;
        logic [CHAN_W-1:0] chan;
        logic [CODE_W-1:0] lo;
        logic [CODE_W-1:0] hi;
    } slot_cfg_t;

    typedef struct packed {
        logic              valid;
        logic [CHAN_W-1:0] chan;
        logic [CODE_W-1:0] code;
    } sample_t;

    typedef enum logic [2:0] {
        RK_CFG,
        RK_LIM,
        RK_FLAGS,
        RK_CTRL,
        RK_NONE
    } reg_kind_e;

    function automatic logic code_above(input logic [CODE_W-1:0] code,
                                        input logic [CODE_W-1:0] bound);
        return code > bound;
    endfunction

    function automatic logic code_below(input logic [CODE_W-1:0] code,
                                        input logic [CODE_W-1:0] bound);
        return code < bound;
    endfunction

endpackage

// File: rtl/adc_lim_regs.sv
module adc_lim_regs
    import adc_lim_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_W    = 2,
    parameter int ADDR_W    = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [DATA_W-1:0]             wdata_i,
    input  logic [2*NUM_SLOTS-1:0]        flags_i,
    output logic [DATA_W-1:0]             rdata_o,
    output slot_cfg_t [NUM_SLOTS-1:0]     cfg_o,
    output logic                          irq_en_o,
    output logic                          wake_en_o,
    output logic [2*NUM_SLOTS-1:0]        flag_clr_o
);

    localparam int FLAG_W = 2 * NUM_SLOTS;

    reg_kind_e         kind;
    logic [SLOT_W-1:0] slot_idx;

    always_comb begin
        slot_idx = addr_i[SLOT_W:1];
        kind     = RK_NONE;
        if (addr_i[ADDR_W-1]) begin
            if (addr_i[ADDR_W-2:0] == '0)
                kind = RK_FLAGS;
            else if (addr_i[ADDR_W-2:0] == 1)
                kind = RK_CTRL;
        end else if (int'(slot_idx) < NUM_SLOTS) begin
            kind = addr_i[0] ? RK_LIM : RK_CFG;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o     <= '0;
            irq_en_o  <= 1'b0;
            wake_en_o <= 1'b0;
        end else if (we_i) begin
            case (kind)
                RK_CFG: begin
                    cfg_o[slot_idx].chan  <= wdata_i[CHAN_W-1:0];
                    cfg_o[slot_idx].lo_en <= wdata_i[CFG_LO_EN_BIT];
                    cfg_o[slot_idx].hi_en <= wdata_i[CFG_HI_EN_BIT];
                end
                RK_LIM: begin
                    cfg_o[slot_idx].lo <= wdata_i[CODE_W-1:0];
                    cfg_o[slot_idx].hi <= wdata_i[LIM_HI_LSB +: CODE_W];
                end
                RK_CTRL: begin
                    irq_en_o  <= wdata_i[CTRL_IRQ_BIT];
                    wake_en_o <= wdata_i[CTRL_WAKE_BIT];
                end
                default: ;
            endcase
        end
    end

    assign flag_clr_o = (we_i && kind == RK_FLAGS) ? wdata_i[FLAG_W-1:0] : '0;

    always_comb begin
        rdata_o = '0;
        case (kind)
            RK_CFG: begin
                rdata_o[CHAN_W-1:0]    = cfg_o[slot_idx].chan;
                rdata_o[CFG_LO_EN_BIT] = cfg_o[slot_idx].lo_en;
                rdata_o[CFG_HI_EN_BIT] = cfg_o[slot_idx].hi_en;
            end
            RK_LIM: begin
                rdata_o[CODE_W-1:0]             = cfg_o[slot_idx].lo;
                rdata_o[LIM_HI_LSB +: CODE_W]   = cfg_o[slot_idx].hi;
            end
            RK_FLAGS: rdata_o[FLAG_W-1:0] = flags_i;
            RK_CTRL: begin
                rdata_o[CTRL_IRQ_BIT]  = irq_en_o;
                rdata_o[CTRL_WAKE_BIT] = wake_en_o;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/adc_lim_cmp.sv
module adc_lim_cmp
    import adc_lim_pkg::*;
(
    input  slot_cfg_t cfg_i,
    input  sample_t   smp_i,
    output logic      lo_hit_o,
    output logic      hi_hit_o
);

    logic chan_match;

    assign chan_match = smp_i.valid && (smp_i.chan == cfg_i.chan);
    assign hi_hit_o   = chan_match && cfg_i.hi_en && code_above(smp_i.code, cfg_i.hi);
    assign lo_hit_o   = chan_match && cfg_i.lo_en && code_below(smp_i.code, cfg_i.lo);

endmodule

// File: rtl/adc_lim_flags.sv
module adc_lim_flags #(
    parameter int FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FLAG_W-1:0] set_i,
    input  logic [FLAG_W-1:0] clr_i,
    input  logic              irq_en_i,
    input  logic              wake_en_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic              irq_o,
    output logic              wake_o
);

    logic [FLAG_W-1:0] flags_q;

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~clr_i) | set_i;
    end

    assign flags_o = flags_q;
    assign irq_o   = irq_en_i  && (|flags_q);
    assign wake_o  = wake_en_i && (|flags_q);

    for (genvar i = 0; i < FLAG_W; i++) begin : g_chk
        // A comparator hit is captured on the next edge, even against a clear
        assert_hit_captured_R8: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> flags_q[i]);
        // No flag appears without a hit
        assert_no_spurious_R5: assert property (@(posedge clk) disable iff (rst)
            (!flags_q[i] && !set_i[i]) |=> !flags_q[i]);
        // Pending flag survives when not cleared
        assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
            (flags_q[i] && !clr_i[i]) |=> flags_q[i]);
        // A clear without a simultaneous hit removes the flag
        assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
            (clr_i[i] && !set_i[i]) |=> !flags_q[i]);
    end

endmodule

// File: rtl/adc_limit_monitor.sv
module adc_limit_monitor
    import adc_lim_pkg::*;
#(
    parameter  int NUM_SLOTS = 4,
    localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int ADDR_W    = SLOT_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid_i,
    input  logic [3:0]        smp_chan_i,
    input  logic [9:0]        smp_code_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              irq_o,
    output logic              wake_o
);

    localparam int FLAG_W = 2 * NUM_SLOTS;

    slot_cfg_t [NUM_SLOTS-1:0] cfg;
    sample_t                   smp;
    logic [FLAG_W-1:0]         hits;
    logic [FLAG_W-1:0]         flag_clr;
    logic [FLAG_W-1:0]         flags;
    logic                      irq_en;
    logic                      wake_en;

    assign smp = '{valid: smp_valid_i, chan: smp_chan_i, code: smp_code_i};

    adc_lim_regs #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .we_i       (reg_we_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .flags_i    (flags),
        .rdata_o    (reg_rdata_o),
        .cfg_o      (cfg),
        .irq_en_o   (irq_en),
        .wake_en_o  (wake_en),
        .flag_clr_o (flag_clr)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        adc_lim_cmp u_cmp (
            .cfg_i    (cfg[s]),
            .smp_i    (smp),
            .lo_hit_o (hits[2*s]),
            .hi_hit_o (hits[2*s+1])
        );
    end

    adc_lim_flags #(.FLAG_W(FLAG_W)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .set_i     (hits),
        .clr_i     (flag_clr),
        .irq_en_i  (irq_en),
        .wake_en_i (wake_en),
        .flags_o   (flags),
        .irq_o     (irq_o),
        .wake_o    (wake_o)
    );

    // Hits only ever come from a strobed sample
    assert_hit_needs_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        (|hits) |-> smp_valid_i);
    // A hit raises the request lines on the next edge when enabled and left alone
    assert_irq_follows_R9: assert property (@(posedge clk) disable iff (rst)
        ((|hits) && irq_en && !reg_we_i) |=> irq_o);
    assert_wake_follows_R10: assert property (@(posedge clk) disable iff (rst)
        ((|hits) && wake_en && !reg_we_i) |=> wake_o);

endmodule

// File: tb/adc_limit_monitor_tb.sv
module adc_limit_monitor_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam logic [3:0] A_FLAGS = 4'd8;
    localparam logic [3:0] A_CTRL  = 4'd9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid_i = 1'b0;
    logic [3:0]  smp_chan_i = '0;
    logic [9:0]  smp_code_i = '0;
    logic        reg_we_i = 1'b0;
    logic [3:0]  reg_addr_i = A_FLAGS;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        irq_o, wake_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model
    logic [3:0] m_chan [NS];
    logic [9:0] m_lo [NS];
    logic [9:0] m_hi [NS];
    logic       m_loen [NS];
    logic       m_hien [NS];
    logic [7:0] m_flags;
    logic       m_irqen, m_wakeen;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_limit_monitor u_dut (
        .clk(clk), .rst(rst),
        .smp_valid_i(smp_valid_i), .smp_chan_i(smp_chan_i), .smp_code_i(smp_code_i),
        .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .irq_o(irq_o), .wake_o(wake_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic peek(input logic [3:0] a, output logic [31:0] d);
        reg_we_i = 1'b0; reg_addr_i = a;
        #1 d = reg_rdata_o;
    endtask

    function automatic logic [7:0] model_hits(input logic v, input logic [3:0] ch, input logic [9:0] c);
        logic [7:0] h = '0;
        for (int s = 0; s < NS; s++) begin
            if (v && ch == m_chan[s]) begin
                h[2*s]   = m_loen[s] && (c < m_lo[s]);
                h[2*s+1] = m_hien[s] && (c > m_hi[s]);
            end
        end
        return h;
    endfunction

    function automatic logic [31:0] model_read(input logic [3:0] a);
        logic [31:0] d = '0;
        if (!a[3]) begin
            if (!a[0]) begin
                d[3:0] = m_chan[a[2:1]]; d[8] = m_loen[a[2:1]]; d[9] = m_hien[a[2:1]];
            end else begin
                d[9:0] = m_lo[a[2:1]]; d[25:16] = m_hi[a[2:1]];
            end
        end else if (a == A_FLAGS) d[7:0] = m_flags;
        else if (a == A_CTRL) d[1:0] = {m_wakeen, m_irqen};
        return d;
    endfunction

    // one clock of stimulus, then model update and output comparison
    task automatic step(input string req, input logic we, input logic [3:0] a, input logic [31:0] wd,
                        input logic v, input logic [3:0] ch, input logic [9:0] c);
        logic [7:0] set, clr;
        logic [31:0] d;
        @(negedge clk);
        reg_we_i = we; reg_addr_i = a; reg_wdata_i = wd;
        smp_valid_i = v; smp_chan_i = ch; smp_code_i = c;
        set = model_hits(v, ch, c);
        clr = (we && a == A_FLAGS) ? wd[7:0] : 8'h0;
        @(posedge clk);
        #1;
        m_flags = (m_flags & ~clr) | set;
        if (we && !a[3]) begin
            if (!a[0]) begin
                m_chan[a[2:1]] = wd[3:0]; m_loen[a[2:1]] = wd[8]; m_hien[a[2:1]] = wd[9];
            end else begin
                m_lo[a[2:1]] = wd[9:0]; m_hi[a[2:1]] = wd[25:16];
            end
        end else if (we && a == A_CTRL) begin
            m_irqen = wd[0]; m_wakeen = wd[1];
        end
        smp_valid_i = 1'b0;
        peek(A_FLAGS, d);
        check({req, " flags"}, d, {24'h0, m_flags});
        check({req, " irq R9"}, {31'h0, irq_o}, {31'h0, m_irqen && (|m_flags)});
        check({req, " wake R10"}, {31'h0, wake_o}, {31'h0, m_wakeen && (|m_flags)});
    endtask

    task automatic wr(input string req, input logic [3:0] a, input logic [31:0] wd);
        step(req, 1'b1, a, wd, 1'b0, 4'h0, 10'h0);
    endtask

    task automatic smp(input string req, input logic [3:0] ch, input logic [9:0] c);
        step(req, 1'b0, A_FLAGS, 32'h0, 1'b1, ch, c);
    endtask

    function automatic logic [31:0] cfgw(input logic [3:0] ch, input logic loen, input logic hien);
        return {22'h0, hien, loen, 4'h0, ch};
    endfunction

    function automatic logic [31:0] limw(input logic [9:0] lo, input logic [9:0] hi);
        return {6'h0, hi, 6'h0, lo};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5A17));
        for (int s = 0; s < NS; s++) begin
            m_chan[s] = '0; m_lo[s] = '0; m_hi[s] = '0; m_loen[s] = 0; m_hien[s] = 0;
        end
        m_flags = '0; m_irqen = 0; m_wakeen = 0;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state of every address and both request lines
        for (int a = 0; a < 16; a++) begin
            peek(a[3:0], d);
            check("R1 reset readback", d, 32'h0);
        end
        check("R1 irq at reset", {31'h0, irq_o}, 32'h0);
        check("R1 wake at reset", {31'h0, wake_o}, 32'h0);

        // R2: field layout and readback, unused addresses ignore writes
        wr("R2", 4'd0, 32'hFFFF_F3F2);
        wr("R2", 4'd1, limw(10'd100, 10'd900) | 32'hFC00_FC00);
        wr("R2", 4'd11, 32'hFFFF_FFFF);
        for (int a = 0; a < 16; a++) begin
            peek(a[3:0], d);
            check("R2 readback", d, model_read(a[3:0]));
        end
        wr("R2", 4'd0, cfgw(4'd2, 1'b1, 1'b1));
        peek(4'd0, d); check("R2 cfg readback", d, 32'h0000_0302);
        peek(4'd1, d); check("R2 limit readback", d, 32'h0384_0064);
        wr("R9", A_CTRL, 32'h1);

        // R3: equal to high bound, then one above
        smp("R3 equal high", 4'd2, 10'd900);
        smp("R3 above high", 4'd2, 10'd901);
        check("R3 hi flag bit", {31'h0, m_flags[1]}, 32'h1);
        // R7: writing 0 leaves the flag
        wr("R7 write zero", A_FLAGS, 32'h0);
        wr("R7 clear", A_FLAGS, 32'h2);
        // R4: equal to low bound, then one below
        smp("R4 equal low", 4'd2, 10'd100);
        smp("R4 below low", 4'd2, 10'd99);
        wr("R7 clear low", A_FLAGS, 32'h1);
        // R5: channel mismatch, no strobe, disabled checks
        smp("R5 other chan", 4'd3, 10'h3FF);
        step("R5 no strobe", 1'b0, A_FLAGS, 0, 1'b0, 4'd2, 10'h3FF);
        wr("R5", 4'd0, cfgw(4'd2, 1'b0, 1'b0));
        smp("R5 disabled high", 4'd2, 10'h3FF);
        smp("R5 disabled low", 4'd2, 10'd0);
        // full-scale and zero bounds never trip
        wr("R3", 4'd0, cfgw(4'd2, 1'b1, 1'b1));
        wr("R3", 4'd1, limw(10'd0, 10'h3FF));
        smp("R3 full scale at bound", 4'd2, 10'h3FF);
        smp("R4 zero at bound", 4'd2, 10'd0);
        // R6: two slots on one channel
        wr("R6", 4'd1, limw(10'd100, 10'd900));
        wr("R6", 4'd2, cfgw(4'd2, 1'b0, 1'b1));
        wr("R6", 4'd3, limw(10'd0, 10'd500));
        smp("R6 one slot", 4'd2, 10'd600);
        smp("R6 both slots", 4'd2, 10'd950);
        // R8: clear and set together
        step("R8 set wins", 1'b1, A_FLAGS, 32'hFF, 1'b1, 4'd2, 10'd950);
        // R10: wake without interrupt
        wr("R10", A_CTRL, 32'h2);
        check("R10 wake only", {30'h0, wake_o, irq_o}, 32'h2);
        wr("R10 clear", A_FLAGS, 32'hFF);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom % 100;
            if (r < 15) begin
                logic [3:0] a = 4'($urandom % 16);
                logic [31:0] wd = $urandom;
                if (!a[3] && !a[0]) wd = cfgw(4'($urandom % 4), 1'($urandom), 1'($urandom));
                else if (!a[3]) begin
                    logic [9:0] lo = 10'($urandom % 512);
                    wd = limw(lo, lo + 10'($urandom % 512));
                end
                step("R2 random write", 1'b1, a, wd, 1'($urandom), 4'($urandom % 6), 10'($urandom));
            end else if (r < 90) begin
                step("R3 R4 R6 random sample", 1'b0, A_FLAGS, 0, 1'b1, 4'($urandom % 6), 10'($urandom));
            end else begin
                step("R7 R8 random clear", 1'b1, A_FLAGS, $urandom, 1'b1, 4'($urandom % 6), 10'($urandom));
            end
        end
        for (int a = 0; a < 16; a++) begin
            peek(a[3:0], d);
            check("R2 final readback", d, model_read(a[3:0]));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule